// File: doc/BRIEF.md
# Dual-View Integer Register File

This block holds the general integer registers of a core that runs two instruction encodings. Its storage is 64 registers of 64 bits, read through two combinational ports and written through one synchronous port. The top register always reads as zero, and writes to it are discarded. Each port carries its own view select. In the wide view the port sees all 64 bits of a register at a 6-bit index. In the narrow view the port sees only the first 16 registers as 32-bit values. A narrow read zero-extends the low half of the register. A narrow write sign-extends the 32-bit value before it is stored.

Next to the general registers sits a 64-entry control space with one read port and one write port. Entry 0 of this space is not separate storage. It is an alias of a 32-bit status register, which holds six named single-bit flags. A flag port updates one flag at a time without touching the other status bits, and a second select reads one flag back. The whole status word is also driven out continuously.

Top module: `dvrf_regfile`

## Requirements
- R1: A wide-view write of a 64-bit value to index k (0..62) is visible one cycle later on either read port in wide view at index k. The two read ports are independent.
- R2: A wide-view read of index 63 returns zero. A write to index 63 has no effect on any register.
- R3: In the narrow view (view select = 1) only bits [3:0] of a port's index are used, so only registers 0..15 are reachable. Bits [5:4] are ignored.
- R4: A narrow-view read returns bits [31:0] of the register in bits [31:0], with bits [63:32] zero.
- R5: A narrow-view write stores bits [31:0] of the write data sign-extended to 64 bits. Write-data bits [63:32] are ignored.
- R6: Reads are combinational. A read of the register being written in the same cycle returns the value from before the write.
- R7: Control entries 1..63 store 64-bit values. A read of control entry 0 returns the status register zero-extended to 64 bits. A write to control entry 0 loads the status register from write-data bits [31:0].
- R8: The flag select codes are: 0 = FP bank select (status bit 14), 1 = FP transfer size (bit 13), 2 = FP precision (bit 12), 3 = divide M (bit 9), 4 = divide Q (bit 8), 5 = saturation (bit 1). A flag update changes only its own bit. Codes 6 and 7 update nothing, and a flag read with code 6 or 7 returns 0.
- R9: When a control write to entry 0 and a flag update happen in the same cycle, the control write sets the whole status register and the flag update is dropped.
- R10: Asynchronous active-low reset clears every general register, every control entry and the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_a_idx_i | input | 6 | Read port A index |
| rd_a_cmp_i | input | 1 | Read port A narrow-view select |
| rd_a_data_o | output | 64 | Read port A data |
| rd_b_idx_i | input | 6 | Read port B index |
| rd_b_cmp_i | input | 1 | Read port B narrow-view select |
| rd_b_data_o | output | 64 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 6 | Write index |
| wr_cmp_i | input | 1 | Write narrow-view select |
| wr_data_i | input | 64 | Write data |
| cr_rd_idx_i | input | 6 | Control read index |
| cr_rd_data_o | output | 64 | Control read data |
| cr_wr_en_i | input | 1 | Control write enable |
| cr_wr_idx_i | input | 6 | Control write index |
| cr_wr_data_i | input | 64 | Control write data |
| flag_wr_en_i | input | 1 | Single-flag update enable |
| flag_wr_sel_i | input | 3 | Flag to update (codes per R8) |
| flag_wr_val_i | input | 1 | New flag value |
| flag_rd_sel_i | input | 3 | Flag to read (codes per R8) |
| flag_rd_o | output | 1 | Selected flag value |
| sr_o | output | 32 | Status register |

## Verification
On every cycle the assertions check a number of properties. A wide write is visible one cycle later. A narrow write reads back sign-extended at its low-four-bit index. Index 63 reads as zero and a narrow read has a zero upper half. Control entry 0 mirrors the status word. A flag update moves no other status bit, and a control write to entry 0 wins over a flag update in the same cycle. Other behaviour only shows in the bench's scenarios: the old value returned when a read and a write hit the same register, discarded writes to index 63, ignored upper index and data bits, inert flag codes 6 and 7, and the cleared state after reset.

// File: rtl/dvrf_pkg.sv
package dvrf_pkg;
  localparam int SR_W = 32;

  localparam int SR_FRBANK_BIT = 14;
  localparam int SR_FSIZE_BIT  = 13;
  localparam int SR_FPREC_BIT  = 12;
  localparam int SR_DIVM_BIT   = 9;
  localparam int SR_DIVQ_BIT   = 8;
  localparam int SR_SAT_BIT    = 1;

  typedef enum logic [2:0] {
    FLAG_FRBANK = 3'd0,
    FLAG_FSIZE  = 3'd1,
    FLAG_FPREC  = 3'd2,
    FLAG_DIVM   = 3'd3,
    FLAG_DIVQ   = 3'd4,
    FLAG_SAT    = 3'd5
  } flag_sel_e;

  // one-hot mask of the flag picked by sel; zero for unused codes
  function automatic logic [SR_W-1:0] flag_mask(logic [2:0] sel);
    logic [SR_W-1:0] m;
    m = '0;
    case (sel)
      FLAG_FRBANK: m[SR_FRBANK_BIT] = 1'b1;
      FLAG_FSIZE:  m[SR_FSIZE_BIT]  = 1'b1;
      FLAG_FPREC:  m[SR_FPREC_BIT]  = 1'b1;
      FLAG_DIVM:   m[SR_DIVM_BIT]   = 1'b1;
      FLAG_DIVQ:   m[SR_DIVQ_BIT]   = 1'b1;
      FLAG_SAT:    m[SR_SAT_BIT]    = 1'b1;
      default:     m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dvrf_gpr_bank.sv
module dvrf_gpr_bank #(
  parameter int XLEN  = 64,
  parameter int NREG  = 64,
  parameter int NRD   = 2,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [IDX_W-1:0] raddr_i [NRD],
  output logic [XLEN-1:0]  rdata_o [NRD]
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NREG - 1);

  logic [XLEN-1:0] mem_q [NREG-1];

  // the top index has no storage
  for (genvar e = 0; e < NREG - 1; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[e] <= '0;
      else if (we_i && waddr_i == IDX_W'(e))
        mem_q[e] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr_i[p] == TOP) rdata_o[p] = '0;
      else                   rdata_o[p] = mem_q[raddr_i[p]];
    end
  end

  // R1
  wr_then_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(we_i) && $past(waddr_i) != TOP &&
     raddr_i[0] == $past(waddr_i)) |-> rdata_o[0] == $past(wdata_i));
endmodule

// File: rtl/dvrf_rd_view.sv
module dvrf_rd_view #(
  parameter int XLEN     = 64,
  parameter int CMP_W    = 32,
  parameter int IDX_W    = 6,
  parameter int CMP_IDXW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] bank_idx_o,
  input  logic [XLEN-1:0]  bank_data_i,
  output logic [XLEN-1:0]  data_o
);
  always_comb begin
    if (cmp_i) begin
      bank_idx_o = {{(IDX_W-CMP_IDXW){1'b0}}, idx_i[CMP_IDXW-1:0]};
      data_o     = {{(XLEN-CMP_W){1'b0}}, bank_data_i[CMP_W-1:0]};
    end else begin
      bank_idx_o = idx_i;
      data_o     = bank_data_i;
    end
  end

  // R3
  narrow_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_i |-> bank_idx_o < IDX_W'(1 << CMP_IDXW));
endmodule

// File: rtl/dvrf_wr_view.sv
module dvrf_wr_view #(
  parameter int XLEN     = 64,
  parameter int CMP_W    = 32,
  parameter int IDX_W    = 6,
  parameter int CMP_IDXW = 4
) (
  input  logic             cmp_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  data_i,
  output logic [IDX_W-1:0] bank_idx_o,
  output logic [XLEN-1:0]  bank_data_o
);
  always_comb begin
    if (cmp_i) begin
      bank_idx_o  = {{(IDX_W-CMP_IDXW){1'b0}}, idx_i[CMP_IDXW-1:0]};
      bank_data_o = {{(XLEN-CMP_W){data_i[CMP_W-1]}}, data_i[CMP_W-1:0]};
    end else begin
      bank_idx_o  = idx_i;
      bank_data_o = data_i;
    end
  end
endmodule

// File: rtl/dvrf_ctrl_space.sv
module dvrf_ctrl_space
  import dvrf_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int NCR   = 64,
  localparam int IDX_W = $clog2(NCR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cr_we_i,
  input  logic [IDX_W-1:0] cr_waddr_i,
  input  logic [XLEN-1:0]  cr_wdata_i,
  input  logic [IDX_W-1:0] cr_raddr_i,
  output logic [XLEN-1:0]  cr_rdata_o,
  input  logic             flag_we_i,
  input  logic [2:0]       flag_wsel_i,
  input  logic             flag_wval_i,
  input  logic [2:0]       flag_rsel_i,
  output logic             flag_rval_o,
  output logic [SR_W-1:0]  sr_o
);
  logic [XLEN-1:0] cr_q [NCR];
  logic [SR_W-1:0] sr_q;
  logic            sr_load;
  logic [SR_W-1:0] fmask;

  assign sr_load = cr_we_i && cr_waddr_i == '0;
  assign fmask   = flag_mask(flag_wsel_i);

  // entry 0 is the status alias, not storage
  assign cr_q[0] = '0;
  for (genvar e = 1; e < NCR; e++) begin : g_cr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cr_q[e] <= '0;
      else if (cr_we_i && cr_waddr_i == IDX_W'(e))
        cr_q[e] <= cr_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      sr_q <= '0;
    else if (sr_load)
      sr_q <= cr_wdata_i[SR_W-1:0];
    else if (flag_we_i)
      sr_q <= (sr_q & ~fmask) | (flag_wval_i ? fmask : '0);
  end

  always_comb begin
    if (cr_raddr_i == '0) cr_rdata_o = {{(XLEN-SR_W){1'b0}}, sr_q};
    else                  cr_rdata_o = cr_q[cr_raddr_i];
  end

  assign flag_rval_o = |(sr_q & flag_mask(flag_rsel_i));
  assign sr_o        = sr_q;

  // R7
  cr0_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_raddr_i == '0 |-> cr_rdata_o == {{(XLEN-SR_W){1'b0}}, sr_o});

  // R8
  flag_isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(flag_we_i) && !$past(sr_load)) |->
    ((sr_o ^ $past(sr_o)) & ~flag_mask($past(flag_wsel_i))) == '0);

  // R9
  sr_load_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sr_load)) |-> sr_o == $past(cr_wdata_i[SR_W-1:0]));
endmodule

// File: rtl/dvrf_regfile.sv
module dvrf_regfile
  import dvrf_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NREG     = 64,
  parameter int CMP_W    = 32,
  parameter int CMP_NREG = 16,
  parameter int NCR      = 64,
  localparam int IDX_W    = $clog2(NREG),
  localparam int CMP_IDXW = $clog2(CMP_NREG),
  localparam int CR_IDXW  = $clog2(NCR),
  localparam int NRD      = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_a_idx_i,
  input  logic               rd_a_cmp_i,
  output logic [XLEN-1:0]    rd_a_data_o,
  input  logic [IDX_W-1:0]   rd_b_idx_i,
  input  logic               rd_b_cmp_i,
  output logic [XLEN-1:0]    rd_b_data_o,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_cmp_i,
  input  logic [XLEN-1:0]    wr_data_i,
  input  logic [CR_IDXW-1:0] cr_rd_idx_i,
  output logic [XLEN-1:0]    cr_rd_data_o,
  input  logic               cr_wr_en_i,
  input  logic [CR_IDXW-1:0] cr_wr_idx_i,
  input  logic [XLEN-1:0]    cr_wr_data_i,
  input  logic               flag_wr_en_i,
  input  logic [2:0]         flag_wr_sel_i,
  input  logic               flag_wr_val_i,
  input  logic [2:0]         flag_rd_sel_i,
  output logic               flag_rd_o,
  output logic [SR_W-1:0]    sr_o
);
  logic [IDX_W-1:0] port_idx  [NRD];
  logic             port_cmp  [NRD];
  logic [XLEN-1:0]  port_data [NRD];
  logic [IDX_W-1:0] bank_ridx [NRD];
  logic [XLEN-1:0]  bank_rdat [NRD];
  logic [IDX_W-1:0] bank_widx;
  logic [XLEN-1:0]  bank_wdat;

  assign port_idx[0] = rd_a_idx_i;
  assign port_cmp[0] = rd_a_cmp_i;
  assign port_idx[1] = rd_b_idx_i;
  assign port_cmp[1] = rd_b_cmp_i;
  assign rd_a_data_o = port_data[0];
  assign rd_b_data_o = port_data[1];

  for (genvar p = 0; p < NRD; p++) begin : g_view
    dvrf_rd_view #(
      .XLEN(XLEN), .CMP_W(CMP_W), .IDX_W(IDX_W), .CMP_IDXW(CMP_IDXW)
    ) u_rd_view (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cmp_i       (port_cmp[p]),
      .idx_i       (port_idx[p]),
      .bank_idx_o  (bank_ridx[p]),
      .bank_data_i (bank_rdat[p]),
      .data_o      (port_data[p])
    );
  end

  dvrf_wr_view #(
    .XLEN(XLEN), .CMP_W(CMP_W), .IDX_W(IDX_W), .CMP_IDXW(CMP_IDXW)
  ) u_wr_view (
    .cmp_i       (wr_cmp_i),
    .idx_i       (wr_idx_i),
    .data_i      (wr_data_i),
    .bank_idx_o  (bank_widx),
    .bank_data_o (bank_wdat)
  );

  dvrf_gpr_bank #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .waddr_i (bank_widx),
    .wdata_i (bank_wdat),
    .raddr_i (bank_ridx),
    .rdata_o (bank_rdat)
  );

  dvrf_ctrl_space #(.XLEN(XLEN), .NCR(NCR)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cr_we_i     (cr_wr_en_i),
    .cr_waddr_i  (cr_wr_idx_i),
    .cr_wdata_i  (cr_wr_data_i),
    .cr_raddr_i  (cr_rd_idx_i),
    .cr_rdata_o  (cr_rd_data_o),
    .flag_we_i   (flag_wr_en_i),
    .flag_wsel_i (flag_wr_sel_i),
    .flag_wval_i (flag_wr_val_i),
    .flag_rsel_i (flag_rd_sel_i),
    .flag_rval_o (flag_rd_o),
    .sr_o        (sr_o)
  );

  // R2
  zero_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_a_cmp_i && rd_a_idx_i == IDX_W'(NREG - 1)) |-> rd_a_data_o == '0);

  // R4
  narrow_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b_cmp_i |-> rd_b_data_o[XLEN-1:CMP_W] == '0);

  // R5
  narrow_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_en_i) && $past(wr_cmp_i) && !rd_a_cmp_i &&
     rd_a_idx_i == {{(IDX_W-CMP_IDXW){1'b0}}, $past(wr_idx_i[CMP_IDXW-1:0])}) |->
    rd_a_data_o == {{(XLEN-CMP_W){$past(wr_data_i[CMP_W-1])}}, $past(wr_data_i[CMP_W-1:0])});
endmodule

// File: tb/dvrf_regfile_test.sv
`timescale 1ns/1ps
module dvrf_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, cr_rd_idx = '0, cr_wr_idx = '0;
  logic        rd_a_cmp = 1'b0, rd_b_cmp = 1'b0, wr_en = 1'b0, wr_cmp = 1'b0, cr_wr_en = 1'b0;
  logic [63:0] wr_data = '0, cr_wr_data = '0;
  logic        flag_wr_en = 1'b0, flag_wr_val = 1'b0;
  logic [2:0]  flag_wr_sel = '0, flag_rd_sel = '0;
  logic [63:0] rd_a_data, rd_b_data, cr_rd_data;
  logic        flag_rd;
  logic [31:0] sr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dvrf_regfile uut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_a_idx_i(rd_a_idx), .rd_a_cmp_i(rd_a_cmp), .rd_a_data_o(rd_a_data),
    .rd_b_idx_i(rd_b_idx), .rd_b_cmp_i(rd_b_cmp), .rd_b_data_o(rd_b_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_cmp_i(wr_cmp), .wr_data_i(wr_data),
    .cr_rd_idx_i(cr_rd_idx), .cr_rd_data_o(cr_rd_data),
    .cr_wr_en_i(cr_wr_en), .cr_wr_idx_i(cr_wr_idx), .cr_wr_data_i(cr_wr_data),
    .flag_wr_en_i(flag_wr_en), .flag_wr_sel_i(flag_wr_sel), .flag_wr_val_i(flag_wr_val),
    .flag_rd_sel_i(flag_rd_sel), .flag_rd_o(flag_rd), .sr_o(sr)
  );

  // {wr_idx, wr_cmp, wr_data, rd_idx, rd_cmp, expected}
  localparam int NV = 8;
  localparam logic [141:0] VEC [NV] = '{
    {6'd5,  1'b0, 64'h1122_3344_5566_7788, 6'd5,  1'b0, 64'h1122_3344_5566_7788}, // R1
    {6'd3,  1'b1, 64'hFFFF_FFFF_8000_0001, 6'd3,  1'b0, 64'hFFFF_FFFF_8000_0001}, // R5
    {6'd3,  1'b1, 64'h1234_5678_8000_0001, 6'd3,  1'b1, 64'h0000_0000_8000_0001}, // R4 R5
    {6'd2,  1'b1, 64'hAAAA_AAAA_7FFF_FFFF, 6'd2,  1'b0, 64'h0000_0000_7FFF_FFFF}, // R5
    {6'd63, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 6'd63, 1'b0, 64'h0},                   // R2
    {6'h31, 1'b1, 64'h0000_0000_DEAD_BEEF, 6'd1,  1'b0, 64'hFFFF_FFFF_DEAD_BEEF}, // R3
    {6'd15, 1'b0, 64'hCAFE_F00D_1234_5678, 6'h2F, 1'b1, 64'h0000_0000_1234_5678}, // R3 R4
    {6'd62, 1'b0, 64'h0123_4567_89AB_CDEF, 6'd62, 1'b0, 64'h0123_4567_89AB_CDEF}  // R1
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic gpr_write(logic [5:0] idx, logic cmp, logic [63:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_cmp = cmp; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cr_write(logic [5:0] idx, logic [63:0] data);
    @(negedge clk);
    cr_wr_en = 1'b1; cr_wr_idx = idx; cr_wr_data = data;
    @(negedge clk);
    cr_wr_en = 1'b0;
  endtask

  task automatic flag_write(logic [2:0] sel, logic val);
    @(negedge clk);
    flag_wr_en = 1'b1; flag_wr_sel = sel; flag_wr_val = val;
    @(negedge clk);
    flag_wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd_a_idx = 6'd0; rd_b_idx = 6'd40; cr_rd_idx = 6'd9; #1;
    chk("R10 gpr0", rd_a_data, 64'h0);
    chk("R10 gpr40", rd_b_data, 64'h0);
    chk("R10 cr9", cr_rd_data, 64'h0);
    chk("R10 sr", {32'h0, sr}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      gpr_write(VEC[i][141:136], VEC[i][135], VEC[i][134:71]);
      rd_a_idx = VEC[i][70:65]; rd_a_cmp = VEC[i][64];
      rd_b_idx = VEC[i][70:65]; rd_b_cmp = VEC[i][64];
      #1;
      chk($sformatf("R1 vec%0d port a", i), rd_a_data, VEC[i][63:0]);
      chk($sformatf("R1 vec%0d port b", i), rd_b_data, VEC[i][63:0]);
    end

    // R1 independent ports
    rd_a_cmp = 1'b0; rd_b_cmp = 1'b0; rd_a_idx = 6'd5; rd_b_idx = 6'd62; #1;
    chk("R1 port a r5", rd_a_data, 64'h1122_3344_5566_7788);
    chk("R1 port b r62", rd_b_data, 64'h0123_4567_89AB_CDEF);

    // R3 narrow write reached only r1, not r49
    rd_a_idx = 6'd49; #1;
    chk("R3 r49 untouched", rd_a_data, 64'h0);

    // R6 same-cycle read returns old value
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd5; wr_cmp = 1'b0; wr_data = 64'h5555_0000_AAAA_1111;
    rd_a_idx = 6'd5; #1;
    chk("R6 old value", rd_a_data, 64'h1122_3344_5566_7788);
    @(negedge clk);
    wr_en = 1'b0; #1;
    chk("R6 new value", rd_a_data, 64'h5555_0000_AAAA_1111);

    // R7 control space
    cr_write(6'd7, 64'hABCD_EF01_2345_6789);
    cr_rd_idx = 6'd7; #1;
    chk("R7 cr7", cr_rd_data, 64'hABCD_EF01_2345_6789);
    cr_write(6'd0, 64'hFFFF_FFFF_0000_7302);
    cr_rd_idx = 6'd0; #1;
    chk("R7 sr load", {32'h0, sr}, 64'h7302);
    chk("R7 cr0 alias", cr_rd_data, 64'h7302);

    // R8 flag updates
    flag_write(3'd3, 1'b0);
    #1; chk("R8 clear divm", {32'h0, sr}, 64'h7102);
    flag_rd_sel = 3'd0; #1;
    chk("R8 read frbank", {63'h0, flag_rd}, 64'h1);
    flag_rd_sel = 3'd3; #1;
    chk("R8 read divm", {63'h0, flag_rd}, 64'h0);
    flag_write(3'd5, 1'b0);
    #1; chk("R8 clear sat", {32'h0, sr}, 64'h7100);
    flag_write(3'd6, 1'b1);
    #1; chk("R8 code6 inert", {32'h0, sr}, 64'h7100);
    flag_rd_sel = 3'd7; #1;
    chk("R8 read code7", {63'h0, flag_rd}, 64'h0);
    chk("R8 cr0 after flags", cr_rd_data, 64'h7100);

    // R9 control write beats flag update
    @(negedge clk);
    cr_wr_en = 1'b1; cr_wr_idx = 6'd0; cr_wr_data = 64'h0;
    flag_wr_en = 1'b1; flag_wr_sel = 3'd5; flag_wr_val = 1'b1;
    @(negedge clk);
    cr_wr_en = 1'b0; flag_wr_en = 1'b0; #1;
    chk("R9 priority", {32'h0, sr}, 64'h0);

    flag_write(3'd2, 1'b1);
    #1; chk("R8 set fprec", {32'h0, sr}, 64'h1000);
    flag_write(3'd4, 1'b1);
    #1; chk("R8 set divq", {32'h0, sr}, 64'h1100);
    cr_rd_idx = 6'd7; #1;
    chk("R7 cr7 kept", cr_rd_data, 64'hABCD_EF01_2345_6789);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule